// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block turns one processor-side operand transfer into the series of external bus cycles that an asynchronous bus of unknown width needs. The requester gives a start address, an operand length of one to four bytes and a direction. For a write it also gives the operand, right-justified in a 32-bit word. The sequencer then opens a bus cycle. On that cycle it drives the full address, a two-bit count of the operand bytes still outstanding, and write data copied onto every byte lane that a narrower port could sample.

The slave ends each cycle with a two-bit active-low acknowledge. The same code also reports the width of the slave's port for that cycle, so the width may change from one cycle to the next. From that width and the low address bits the sequencer works out how many bytes the slave took. It then moves the address forward, lowers the outstanding count, and either opens a follow-on cycle or finishes. On reads, the bytes that arrive on the port's lanes are collected into a 32-bit result, right-justified. A cycle-start pulse marks every cycle and an operand-start pulse marks only the first.

The operand is big-endian. Its most significant byte lives at the start address and is sent first. The external data bus numbers its lanes from the top: the byte at address offset 0 of a 32-bit port is data[31:24], and offset 3 is data[7:0]. A 16-bit port sits on data[31:16] and an 8-bit port on data[31:24].

Top module: `bus_sizer`

## Requirements
- R1: After reset, bus_active, cyc_start, op_start and done are all 0.
- R2: In the clock after req_valid is seen while idle, bus_active, cyc_start and op_start are 1. bus_addr equals req_addr, bus_siz equals req_size and bus_read is the inverse of req_write. Size encoding: 01 means 1 byte, 10 means 2 bytes, 11 means 3 bytes and 00 means 4 bytes.
- R3: An ack_n of 11 means wait, and while it is 11 the bus_addr, bus_siz and bus_active outputs hold. ack_n is ignored in the clock where cyc_start is 1, so every bus cycle lasts at least two clocks.
- R4: The ack_n codes give the port width: 10 is 1 byte, 01 is 2 bytes and 00 is 4 bytes. With width W, the bytes taken are min(W minus (address mod W), remaining). If bytes remain, the next clock shows cyc_start 1 and op_start 0, with bus_addr advanced by the bytes taken and bus_siz set to the new remaining count.
- R5: When the remaining count reaches zero, the next clock shows done at 1 and bus_active at 0. done lasts exactly one clock.
- R6: On a read, rdata presented with done holds the operand right-justified. The byte at start address plus i is placed in rdata byte n-1-i, and upper unused bytes are 0. Port lane L is data[31-8L -: 8]. A 4-byte port starts at lane (address mod 4), a 2-byte port at lane (address mod 2), and a 1-byte port at lane 0.
- R7: On a write, each lane the current port will sample carries the correct operand byte. The lanes begin at the R6 starting lane for that port width, and lane start+k carries operand byte remaining-1-k, counted from the least significant byte. This holds for every port width, before the width is known.
- R8: A req_valid that arrives while a transfer is in progress is ignored. The address does not change, no operand-start appears, and the transfer in progress completes normally.
- R9: The port width may differ on each cycle of one operand, and the assembled read result is still correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transfer (accepted only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 2 | Operand length code |
| req_wdata | input | 32 | Write operand, right-justified |
| ack_n | input | 2 | Active-low acknowledge / port width code |
| bus_rdata | input | 32 | External read data lanes |
| bus_active | output | 1 | A transfer's bus cycles are in progress |
| cyc_start | output | 1 | First clock of every bus cycle |
| op_start | output | 1 | First clock of an operand's first bus cycle |
| bus_read | output | 1 | Direction of the bus cycle, 1 = read |
| bus_addr | output | ADDR_W | Current cycle byte address |
| bus_siz | output | 2 | Bytes still to be transferred, same encoding |
| bus_wdata | output | 32 | Steered write data lanes |
| done | output | 1 | One-clock pulse at the end of a transfer |
| rdata | output | 32 | Assembled read operand |

## Verification
The hardest case is a three- or four-cycle operand whose port width changes between cycles. In that case each follow-on cycle starts at a different lane offset, and the collected bytes must land in shifting positions. The bench reaches it with a directed read whose widths are 8, then 32, then 16 bits. It also runs random operands in which the slave picks a fresh width and wait count for every cycle. Two further directed operands cover acknowledges raised during the start clock and requests raised while busy, both at points where a wrong design would visibly advance or restart.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int CNT_W  = 3;

  // length code to byte count: 00 stands for a full word
  function automatic logic [CNT_W-1:0] code_to_count(input logic [1:0] code);
    return (code == 2'b00) ? CNT_W'(4) : {1'b0, code};
  endfunction

  function automatic logic [1:0] count_to_code(input logic [CNT_W-1:0] cnt);
    return cnt[1:0];
  endfunction

  // active-low response to port width in bytes, 0 while waiting
  function automatic logic [CNT_W-1:0] ack_to_width(input logic [1:0] ack);
    case (ack)
      2'b10:   return CNT_W'(1);
      2'b01:   return CNT_W'(2);
      2'b00:   return CNT_W'(4);
      default: return CNT_W'(0);
    endcase
  endfunction

  // byte driven on lane p so that 8-, 16- and 32-bit ports all see their byte
  function automatic logic [7:0] steer_byte(input int p, input logic [1:0] alo,
                                            input logic [CNT_W-1:0] rem,
                                            input logic [DATA_W-1:0] opnd);
    int k;
    int idx;
    if (p >= int'(alo))            k = p - int'(alo);
    else if (p == 1 && !alo[0])    k = 1;
    else                           k = 0;
    idx = int'(rem) - 1 - k;
    if (idx < 0) return 8'h00;
    return opnd[8*idx +: 8];
  endfunction

endpackage

// File: rtl/bsz_accept_calc.sv
module bsz_accept_calc
  import bsz_pkg::*;
(
  input  logic [1:0]       addr_lo,
  input  logic [CNT_W-1:0] remain,
  input  logic [CNT_W-1:0] width,
  output logic [CNT_W-1:0] taken,
  output logic [1:0]       lane_start
);
  logic [1:0]       offset;
  logic [CNT_W-1:0] room;

  always_comb begin
    case (width)
      CNT_W'(4): offset = addr_lo;
      CNT_W'(2): offset = {1'b0, addr_lo[0]};
      default:   offset = 2'b00;
    endcase
    room       = width - {1'b0, offset};
    taken      = (width == '0) ? '0 : ((room < remain) ? room : remain);
    lane_start = offset;
  end
endmodule

// File: rtl/bsz_write_steer.sv
module bsz_write_steer
  import bsz_pkg::*;
(
  input  logic [1:0]        addr_lo,
  input  logic [CNT_W-1:0]  remain,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] lanes
);
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    assign lanes[DATA_W-1-8*p -: 8] = steer_byte(p, addr_lo, remain, operand);
  end
endmodule

// File: rtl/bsz_read_merge.sv
module bsz_read_merge
  import bsz_pkg::*;
(
  input  logic [DATA_W-1:0] partial,
  input  logic [DATA_W-1:0] bus_lanes,
  input  logic [1:0]        lane_start,
  input  logic [CNT_W-1:0]  taken,
  input  logic [CNT_W-1:0]  remain,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    merged = partial;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(taken)) begin
        merged[8*(int'(remain)-1-k) +: 8] =
          bus_lanes[DATA_W-1-8*(int'(lane_start)+k) -: 8];
      end
    end
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        ack_n,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_active,
  output logic              cyc_start,
  output logic              op_start,
  output logic              bus_read,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic              active_q, cyc_q, op_q, done_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [DATA_W-1:0] opnd_q, wdata_q, part_q, rdata_q;

  logic [CNT_W-1:0]  width, taken, next_rem, steer_rem;
  logic [1:0]        lane_start, steer_alo;
  logic [ADDR_W-1:0] next_addr;
  logic [DATA_W-1:0] merged, steered, steer_opnd;
  logic              take;

  assign width     = ack_to_width(ack_n);
  assign take      = active_q && !cyc_q && (width != '0);
  assign next_rem  = rem_q - taken;
  assign next_addr = addr_q + {{(ADDR_W-CNT_W){1'b0}}, taken};

  bsz_accept_calc u_calc (
    .addr_lo    (addr_q[1:0]),
    .remain     (rem_q),
    .width      (width),
    .taken      (taken),
    .lane_start (lane_start)
  );

  bsz_read_merge u_merge (
    .partial    (part_q),
    .bus_lanes  (bus_rdata),
    .lane_start (lane_start),
    .taken      (taken),
    .remain     (rem_q),
    .merged     (merged)
  );

  // one steering network serves both the opening cycle and follow-on cycles
  assign steer_alo  = active_q ? next_addr[1:0] : req_addr[1:0];
  assign steer_rem  = active_q ? next_rem : code_to_count(req_size);
  assign steer_opnd = active_q ? opnd_q : req_wdata;

  bsz_write_steer u_steer (
    .addr_lo (steer_alo),
    .remain  (steer_rem),
    .operand (steer_opnd),
    .lanes   (steered)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cyc_q    <= 1'b0;
      op_q     <= 1'b0;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      opnd_q   <= '0;
      wdata_q  <= '0;
      part_q   <= '0;
      rdata_q  <= '0;
    end else begin
      cyc_q  <= 1'b0;
      op_q   <= 1'b0;
      done_q <= 1'b0;
      if (!active_q) begin
        if (req_valid) begin
          active_q <= 1'b1;
          cyc_q    <= 1'b1;
          op_q     <= 1'b1;
          wr_q     <= req_write;
          addr_q   <= req_addr;
          rem_q    <= code_to_count(req_size);
          opnd_q   <= req_wdata;
          wdata_q  <= steered;
          part_q   <= '0;
        end
      end else if (take) begin
        if (!wr_q) part_q <= merged;
        if (next_rem == '0) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          if (!wr_q) rdata_q <= merged;
        end else begin
          cyc_q   <= 1'b1;
          addr_q  <= next_addr;
          rem_q   <= next_rem;
          wdata_q <= steered;
        end
      end
    end
  end

  assign bus_active = active_q;
  assign cyc_start  = cyc_q;
  assign op_start   = op_q;
  assign bus_read   = !wr_q;
  assign bus_addr   = addr_q;
  assign bus_siz    = count_to_code(rem_q);
  assign bus_wdata  = wdata_q;
  assign done       = done_q;
  assign rdata      = rdata_q;
endmodule

// File: rtl/bsz_checker.sv
module bsz_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        ack_n,
  input logic              bus_active,
  input logic              cyc_start,
  input logic              op_start,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz
);
  a_r2_opstart_in_cycle: assert property (@(posedge clk) disable iff (rst)
    op_start |-> (cyc_start && bus_active));

  a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (bus_active && !cyc_start && ack_n == 2'b11) |=>
      ($stable(bus_addr) && $stable(bus_siz) && bus_active));

  a_r3_start_clock_ignores_ack: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> (bus_active && !cyc_start && !done));

  a_r4_followon_moves_addr: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !op_start) |-> (bus_addr != $past(bus_addr)));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_active);

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_no_restart_busy: assert property (@(posedge clk) disable iff (rst)
    (bus_active && req_valid) |=> !op_start);
endmodule

bind bus_sizer bsz_checker #(.ADDR_W(ADDR_W)) u_bsz_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .ack_n      (ack_n),
  .bus_active (bus_active),
  .cyc_start  (cyc_start),
  .op_start   (op_start),
  .done       (done),
  .bus_addr   (bus_addr),
  .bus_siz    (bus_siz)
);

// File: tb/bus_sizer_bench.sv
module bus_sizer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  ack_n = 2'b11;
  logic [31:0] bus_rdata = '0;
  logic        bus_active, cyc_start, op_start, bus_read, done;
  logic [31:0] bus_addr, bus_wdata, rdata;
  logic [1:0]  bus_siz;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_sizer u_bus_sizer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .ack_n(ack_n), .bus_rdata(bus_rdata), .bus_active(bus_active),
    .cyc_start(cyc_start), .op_start(op_start), .bus_read(bus_read),
    .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_wdata(bus_wdata),
    .done(done), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [1:0] width_code(input int w);
    return (w == 1) ? 2'b10 : (w == 2) ? 2'b01 : 2'b00;
  endfunction

  // wsel: 0/1/2 fixed 8/16/32-bit port, 3 random per cycle, 4 the sequence 8,32,16
  task automatic run_op(input bit wr, input logic [31:0] a, input int n,
                        input logic [31:0] d, input int wsel,
                        input bit poke_ack, input bit poke_req);
    logic [31:0] ca, expr, lanes;
    int rem, cons, w, off, room, acc, cnt, waits;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_size = 2'(n); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    ca = a; rem = n; cons = 0; cnt = 0; expr = '0;
    for (int i = 0; i < n; i++) expr[8*(n-1-i) +: 8] = mem_byte(a + 32'(i));
    while (rem > 0 && cnt < 8) begin
      cnt++;
      chk(cyc_start && bus_active, cnt == 1 ? "R2 cycle opens" : "R4 follow-on opens",
          {30'd0, cyc_start, bus_active}, 32'd3);
      chk(op_start == (cnt == 1), "R4 operand-start only first",
          {31'd0, op_start}, {31'd0, cnt == 1});
      chk(bus_addr == ca, "R4 cycle address", bus_addr, ca);
      chk(bus_siz == 2'(rem), "R4 size code", {30'd0, bus_siz}, 32'(rem & 3));
      chk(bus_read == !wr, "R2 direction", {31'd0, bus_read}, {31'd0, !wr});
      case (wsel)
        0: w = 1;
        1: w = 2;
        2: w = 4;
        4: w = (cnt == 1) ? 1 : (cnt == 2) ? 4 : 2;
        default: w = 1 << ($urandom % 3);
      endcase
      off  = (w == 4) ? int'(ca[1:0]) : (w == 2) ? int'(ca[0]) : 0;
      room = w - off;
      acc  = (room < rem) ? room : rem;
      if (poke_ack && cnt == 1) ack_n = width_code(w);
      @(negedge clk);
      ack_n = 2'b11;
      if (poke_ack && cnt == 1)
        chk(!cyc_start && bus_active && !done && bus_addr == ca,
            "R3 ack in start clock ignored", bus_addr, ca);
      waits = poke_req ? 1 : int'($urandom % 3);
      for (int j = 0; j < waits; j++) begin
        if (poke_req && j == 0) begin
          req_valid = 1'b1; req_addr = ~a;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_addr == ca && !cyc_start && bus_active, "R3 hold on wait", bus_addr, ca);
        if (poke_req && j == 0)
          chk(!op_start && bus_siz == 2'(rem), "R8 request ignored while busy",
              {31'd0, op_start}, 32'd0);
      end
      lanes = {4{8'hEE}};
      for (int k = 0; k < room; k++)
        lanes[31-8*(off+k) -: 8] = mem_byte(ca + 32'(k));
      bus_rdata = lanes;
      if (wr) begin
        for (int k = 0; k < acc; k++)
          chk(bus_wdata[31-8*(off+k) -: 8] == d[8*(n-1-cons-k) +: 8], "R7 write lane",
              {24'd0, bus_wdata[31-8*(off+k) -: 8]}, {24'd0, d[8*(n-1-cons-k) +: 8]});
      end
      ack_n = width_code(w);
      @(negedge clk);
      ack_n = 2'b11;
      rem -= acc; cons += acc; ca += 32'(acc);
    end
    chk(done && !bus_active, "R5 done after last byte", {30'd0, done, bus_active}, 32'd2);
    if (!wr)
      chk(rdata == expr, wsel == 4 ? "R9 mixed widths result" : "R6 read result", rdata, expr);
    @(negedge clk);
    chk(!done && !bus_active && !cyc_start, "R5 done single clock",
        {29'd0, done, bus_active, cyc_start}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_active && !cyc_start && !op_start && !done, "R1 reset state",
        {28'd0, bus_active, cyc_start, op_start, done}, 32'd0);
    // directed corner cases
    run_op(1'b0, 32'h0000_1000, 4, 32'h0, 2, 1'b0, 1'b0);
    run_op(1'b0, 32'h0000_2003, 4, 32'h0, 2, 1'b0, 1'b0);
    run_op(1'b1, 32'h0000_3001, 4, 32'hA1B2C3D4, 0, 1'b0, 1'b0);
    run_op(1'b1, 32'h0000_4002, 3, 32'h00112233, 1, 1'b0, 1'b0);
    run_op(1'b1, 32'h0000_5003, 2, 32'h0000BEEF, 1, 1'b0, 1'b0);
    run_op(1'b0, 32'h0000_6001, 4, 32'h0, 4, 1'b0, 1'b0);
    run_op(1'b0, 32'h0000_7002, 1, 32'h0, 2, 1'b1, 1'b0);
    run_op(1'b1, 32'hFFFF_FFFE, 4, 32'h55667788, 2, 1'b0, 1'b1);
    // random operands with per-cycle port widths
    for (int t = 0; t < 60; t++) begin
      int n;
      n = 1 + int'($urandom % 4);
      run_op(1'($urandom), $urandom, n, $urandom, 3, 1'b0, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule